// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block holds two command registers that let two independently clocked ports pass single words to each other without going through the data FIFO. Port A owns the outbound register (mail1), which port B reads. Port B owns the return register (mail2), which port A reads. On each port, a select input decides whether an access goes to the mailbox or to the FIFO. An access counts only when chip select, enable and the read/write direction are all sampled valid on that port's rising clock edge.

Each register has an active-low flag on its writer's side. A write drives the flag low and locks the register. The reader's consuming read then travels back through a two-flop synchronizer and drives the flag high again. This makes each mailbox a one-deep handshake that is safe across the two clock domains.

The block also contains the port-B read multiplexer, which selects either the FIFO output word or mail1. Port A always sees mail2. The FIFO is outside the block; its output word arrives as an input.

Top module: `cc_mailbox_pair`

## Requirements
- R1: While `rst_n` is low, both flags are high (empty) and both registers read as zero.
- R2: A port-A access with `a_cs`, `a_en`, `a_wr` and `a_mbox` all high, taken while `mb1_flag` is high, loads `a_wdata` into mail1 on that `clk_a` edge.
- R3: `mb1_flag` goes low on the same `clk_a` edge that accepts a mail1 write, and falls at no other time.
- R4: A mailbox write attempted while that mailbox's flag is low is ignored. The register keeps its old contents.
- R5: A port-B read of pending mail1 (`b_cs`, `b_en`, `b_mbox` high, `b_wr` low) leaves `mb1_flag` low after the first later `clk_a` edge. The flag goes high on the second `clk_a` edge.
- R6: `b_rdata` equals `fifo_q` when `b_mbox` is low and equals mail1 when `b_mbox` is high.
- R7: `a_rdata` always shows mail2.
- R8: A port-B mailbox write (`b_wr` high), taken while `mb2_flag` is high, loads mail2 and drives `mb2_flag` low on that `clk_b` edge. A port-A read of pending mail2 (`a_wr` low) leaves `mb2_flag` low after the first later `clk_b` edge. The flag goes high on the second `clk_b` edge.
- R9: An access with chip select low, enable low, or mailbox select low changes neither register nor either flag.
- R10: A mailbox read is ignored unless the matching write has already crossed into the reader's clock domain, which takes two reader clock edges after the write. An ignored read leaves the writer's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port-A clock |
| a_cs | input | 1 | Port-A chip select, active high |
| a_wr | input | 1 | Port-A direction: 1 write, 0 read |
| a_en | input | 1 | Port-A access enable |
| a_mbox | input | 1 | Port-A select: 1 mailbox, 0 FIFO |
| a_wdata | input | DATA_W | Port-A write word |
| a_rdata | output | DATA_W | Port-A read word (mail2) |
| mb1_flag | output | 1 | Mail1 flag in the `clk_a` domain; low means full |
| clk_b | input | 1 | Port-B clock |
| b_cs | input | 1 | Port-B chip select, active high |
| b_wr | input | 1 | Port-B direction: 1 write, 0 read |
| b_en | input | 1 | Port-B access enable |
| b_mbox | input | 1 | Port-B select: 1 mailbox, 0 FIFO |
| b_wdata | input | DATA_W | Port-B write word |
| fifo_q | input | DATA_W | FIFO output register word |
| b_rdata | output | DATA_W | Port-B read word (FIFO or mail1) |
| mb2_flag | output | 1 | Mail2 flag in the `clk_b` domain; low means full |

## Verification
A toggle pair that falls out of step shows up right away at the ports. Either a flag goes low with no write, or a flag stays low for good and every later write is blocked. A stale or wrong synchronizer stage moves the flag release off its expected second edge, so the bench watches the flag on each of the first two writer edges after a read. A register that loads when it should not changes `b_rdata` or `a_rdata` on the very next sample.

// File: rtl/cc_mailbox_pair.sv
module cc_mailbox_pair #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              clk_a,
  input  logic              a_cs,
  input  logic              a_wr,
  input  logic              a_en,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              mb1_flag,
  input  logic              clk_b,
  input  logic              b_cs,
  input  logic              b_wr,
  input  logic              b_en,
  input  logic              b_mbox,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] b_rdata,
  output logic              mb2_flag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [DATA_W-1:0] mail1_q, mail2_q;
  logic              w1_tog, r1_tog, w2_tog, r2_tog;
  logic [LAST:0]     w1_sync_b, r1_sync_a, w2_sync_a, r2_sync_b;
  logic              a_hit, b_hit, a_put, a_take, b_put, b_take;
  logic              mb1_pend_b, mb2_pend_a;

  assign mb1_flag   = ~(w1_tog ^ r1_sync_a[LAST]);
  assign mb2_flag   = ~(w2_tog ^ r2_sync_b[LAST]);
  assign mb1_pend_b = w1_sync_b[LAST] ^ r1_tog;
  assign mb2_pend_a = w2_sync_a[LAST] ^ r2_tog;

  assign a_hit  = a_cs & a_en & a_mbox;
  assign b_hit  = b_cs & b_en & b_mbox;
  assign a_put  = a_hit &  a_wr & mb1_flag;
  assign a_take = a_hit & ~a_wr & mb2_pend_a;
  assign b_put  = b_hit &  b_wr & mb2_flag;
  assign b_take = b_hit & ~b_wr & mb1_pend_b;

  assign a_rdata = mail2_q;
  assign b_rdata = b_mbox ? mail1_q : fifo_q;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1_q   <= '0;
      w1_tog    <= 1'b0;
      r2_tog    <= 1'b0;
      r1_sync_a <= '0;
      w2_sync_a <= '0;
    end else begin
      if (a_put) begin
        mail1_q <= a_wdata;
        w1_tog  <= ~w1_tog;
      end
      if (a_take) r2_tog <= ~r2_tog;
      r1_sync_a <= {r1_sync_a[LAST-1:0], r1_tog};
      w2_sync_a <= {w2_sync_a[LAST-1:0], w2_tog};
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2_q   <= '0;
      w2_tog    <= 1'b0;
      r1_tog    <= 1'b0;
      w1_sync_b <= '0;
      r2_sync_b <= '0;
    end else begin
      if (b_put) begin
        mail2_q <= b_wdata;
        w2_tog  <= ~w2_tog;
      end
      if (b_take) r1_tog <= ~r1_tog;
      w1_sync_b <= {w1_sync_b[LAST-1:0], w1_tog};
      r2_sync_b <= {r2_sync_b[LAST-1:0], r2_tog};
    end
  end
endmodule

// File: rtl/cc_mailbox_pair_chk.sv
module cc_mailbox_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              rst_n,
  input logic              clk_a,
  input logic              a_cs,
  input logic              a_wr,
  input logic              a_en,
  input logic              a_mbox,
  input logic              mb1_flag,
  input logic              clk_b,
  input logic              b_cs,
  input logic              b_wr,
  input logic              b_en,
  input logic              b_mbox,
  input logic              mb2_flag,
  input logic [DATA_W-1:0] mail1_q,
  input logic [DATA_W-1:0] mail2_q
);
  a_r3_flag1_low_after_put: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_cs && a_en && a_wr && a_mbox && mb1_flag) |=> !mb1_flag);

  a_r3_flag1_falls_only_on_put: assert property (@(posedge clk_a) disable iff (!rst_n)
    $fell(mb1_flag) |-> $past(a_cs && a_en && a_wr && a_mbox));

  a_r4_mail1_held_while_full: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_cs && a_en && a_wr && a_mbox && !mb1_flag) |=> $stable(mail1_q));

  a_r8_flag2_low_after_put: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_cs && b_en && b_wr && b_mbox && mb2_flag) |=> !mb2_flag);

  a_r8_flag2_falls_only_on_put: assert property (@(posedge clk_b) disable iff (!rst_n)
    $fell(mb2_flag) |-> $past(b_cs && b_en && b_wr && b_mbox));

  a_r4_mail2_held_while_full: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_cs && b_en && b_wr && b_mbox && !mb2_flag) |=> $stable(mail2_q));
endmodule

bind cc_mailbox_pair cc_mailbox_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cc_mailbox_pair.sv
`timescale 1ns/100ps
module tb_cc_mailbox_pair;
  localparam int W = 36;

  logic rst_n = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mbox = 0;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mbox = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_q = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic mb1_flag, mb2_flag;
  int total = 0, bad = 0;

  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  cc_mailbox_pair dut (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(logic wr, logic mbox, logic [W-1:0] d, logic cs = 1, logic en = 1);
    @(negedge clk_a);
    a_cs = cs; a_en = en; a_wr = wr; a_mbox = mbox; a_wdata = d;
    @(posedge clk_a); #0.5;
    a_cs = 0; a_en = 0; a_wr = 0; a_mbox = 0;
  endtask

  task automatic b_op(logic wr, logic [W-1:0] d, logic cs = 1, logic en = 1, logic mbox = 1);
    @(negedge clk_b);
    b_cs = cs; b_en = en; b_wr = wr; b_mbox = mbox; b_wdata = d;
    @(posedge clk_b); #0.5;
    b_cs = 0; b_en = 0; b_wr = 0; b_mbox = 1;
  endtask

  task automatic t_reset;
    b_mbox = 1; #0.5;
    check("R1 mb1_flag", W'(mb1_flag), W'(1));
    check("R1 mb2_flag", W'(mb2_flag), W'(1));
    check("R1 mail2", a_rdata, '0);
    check("R1 mail1", b_rdata, '0);
  endtask

  task automatic t_a_to_b(logic [W-1:0] d1, logic [W-1:0] d2);
    a_op(1, 1, d1);
    check("R3 flag low after write", W'(mb1_flag), W'(0));
    check("R2 mail1 loaded", b_rdata, d1);
    a_op(1, 1, d2);
    check("R4 write while full ignored", b_rdata, d1);
    check("R4 flag stays low", W'(mb1_flag), W'(0));
    repeat (3) @(posedge clk_b);
    b_op(0, '0);
    @(posedge clk_a); #0.5;
    check("R5 flag low after first edge", W'(mb1_flag), W'(0));
    @(posedge clk_a); #0.5;
    check("R5 flag high on second edge", W'(mb1_flag), W'(1));
  endtask

  task automatic t_mux(logic [W-1:0] f);
    fifo_q = f; b_mbox = 0; #0.5;
    check("R6 fifo selected", b_rdata, f);
    b_mbox = 1; #0.5;
    check("R6 mail1 selected", b_rdata, dut_mail1_exp);
  endtask

  logic [W-1:0] dut_mail1_exp = '0;

  task automatic t_b_to_a(logic [W-1:0] d3, logic [W-1:0] d4);
    b_op(1, d3);
    check("R8 flag2 low after write", W'(mb2_flag), W'(0));
    check("R7 a_rdata shows mail2", a_rdata, d3);
    b_op(1, d4);
    check("R4 mail2 write while full ignored", a_rdata, d3);
    repeat (3) @(posedge clk_a);
    a_op(0, 1, '0);
    check("R8 flag2 still low at read", W'(mb2_flag), W'(0));
    @(posedge clk_b); #0.5;
    check("R8 flag2 low after first edge", W'(mb2_flag), W'(0));
    @(posedge clk_b); #0.5;
    check("R8 flag2 high on second edge", W'(mb2_flag), W'(1));
    check("R7 a_rdata holds mail2", a_rdata, d3);
  endtask

  task automatic t_qualify(logic [W-1:0] d);
    a_op(1, 1, d, 1, 0);
    check("R9 enable low ignored flag", W'(mb1_flag), W'(1));
    check("R9 enable low ignored data", b_rdata, dut_mail1_exp);
    a_op(1, 1, d, 0, 1);
    check("R9 cs low ignored flag", W'(mb1_flag), W'(1));
    check("R9 cs low ignored data", b_rdata, dut_mail1_exp);
    a_op(1, 0, d);
    check("R9 fifo access leaves flag", W'(mb1_flag), W'(1));
    check("R9 fifo access leaves mail1", b_rdata, dut_mail1_exp);
    b_op(1, d, 1, 1, 0);
    check("R9 b fifo access leaves flag2", W'(mb2_flag), W'(1));
  endtask

  task automatic t_spurious(logic [W-1:0] d);
    b_op(0, '0);
    repeat (4) @(posedge clk_a); #0.5;
    check("R10 empty read ignored", W'(mb1_flag), W'(1));
    a_op(1, 1, d);
    b_op(0, '0);
    repeat (4) @(posedge clk_a); #0.5;
    check("R10 early read ignored", W'(mb1_flag), W'(0));
    b_op(0, '0);
    repeat (3) @(posedge clk_a); #0.5;
    check("R10 later read accepted", W'(mb1_flag), W'(1));
  endtask

  bit done = 0;
  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_b);
    t_reset();
    @(negedge clk_a); rst_n = 1;
    t_a_to_b(36'h1_2345_6789, 36'hF_0F0F_0F0F); dut_mail1_exp = 36'h1_2345_6789;
    t_mux(36'hA_AAAA_5555);
    t_mux(36'h0_0000_0001);
    t_a_to_b(36'hF_FFFF_FFFF, 36'h0_0000_0000); dut_mail1_exp = 36'hF_FFFF_FFFF;
    t_b_to_a(36'h8_0000_0001, 36'h7_7777_7777);
    t_qualify(36'h3_3333_3333);
    t_spurious(36'h5_A5A5_A5A5); dut_mail1_exp = 36'h5_A5A5_A5A5;
    #0.5;
    check("R2 last mail1", b_rdata, dut_mail1_exp);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule